// File: doc/BRIEF.md
# Set-Only Latching Register Bank

This block holds four 8-bit general purpose registers, called A, B, C and D, on one shared data bus. Each register acts like a bank of latching relays. A load can only turn bits on. The value is then kept by a separate hold control, and the register empties as soon as neither hold nor load is active. A register that is selected puts its contents on the bus.

The bus is modelled as a wired OR, so a held register that is selected while the external bus is not empty picks up the bus bits. Registers B and C feed the two ALU operand outputs at all times. Registers A and D can also be loaded from the ALU result, chosen by a per-register source input. Every register has a status output for per-bit indicators. Driving load and hold together on one register is an illegal request: the block flags it and keeps the held value.

Control vectors `load`, `hold` and `sel` use bit 0 for A, bit 1 for B, bit 2 for C and bit 3 for D. The `status` output packs register i into bits `[8*i+7:8*i]` in the same order.

Top module: `relay_reg_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four registers become zero. After that edge, `status`, `bus_out`, `alu_op_b` and `alu_op_c` read zero.
- R2: When a register has load high and hold low, its next value is the current value ORed with its load source. A load never clears a bit.
- R3: When a register has hold high and load low and is not selected, its value is kept unchanged.
- R4: When a register has both load and hold low, it reads zero after the next clock edge.
- R5: When a register has load and hold high together, its bit in `conflict` is 1 in the same cycle and its value is kept. Otherwise that `conflict` bit is 0.
- R6: When a register has hold high, load low and select high, its next value is the current value ORed with `bus_in`.
- R7: `bus_out` equals the bitwise OR of the stored values of all registers whose `sel` bit is 1. It is zero when `sel` is zero.
- R8: `alu_op_b` always equals register B and `alu_op_c` always equals register C.
- R9: Register A loads from `alu_result` when `src_alu_a` is 1, otherwise from `bus_in`. Register D does the same under `src_alu_d`. Registers B and C always load from `bus_in`, so `alu_result` has no effect on them.
- R10: `status` shows all four stored values at all times, packed as described above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 4 | Per-register load request (bit 0 = A … bit 3 = D) |
| hold | input | 4 | Per-register hold control |
| sel | input | 4 | Per-register drive-onto-bus select |
| src_alu_a | input | 1 | Register A load source: 1 = ALU result, 0 = bus |
| src_alu_d | input | 1 | Register D load source: 1 = ALU result, 0 = bus |
| bus_in | input | 8 | Value other drivers place on the shared bus |
| alu_result | input | 8 | ALU result word |
| bus_out | output | 8 | OR of the selected registers |
| alu_op_b | output | 8 | First ALU operand (register B) |
| alu_op_c | output | 8 | Second ALU operand (register C) |
| status | output | 32 | Indicator mirror of all four registers |
| conflict | output | 4 | Per-register illegal load-with-hold flag |

## Verification
The bench targets the points where the set-only latch differs from an ordinary register. It checks that a second load ORs into the stored value instead of replacing it; a design that overwrites would lose earlier bits. It checks that dropping hold empties the register, which a plain flop would not do. It checks that a held, selected register absorbs a nonzero external bus; a design without this back-feed would keep its old value. It also checks that a load requested together with hold leaves the value untouched and raises the flag, and that `alu_result` reaches only A and D, and only when their source input picks it; miswired source muxes would corrupt B or C.

// File: rtl/relay_bank_pkg.sv
package relay_bank_pkg;

    parameter int DATA_W   = 8;
    parameter int NUM_REGS = 4;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        IDX_A = 2'd0,
        IDX_B = 2'd1,
        IDX_C = 2'd2,
        IDX_D = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic load;
        logic hold;
        logic sel;
    } cell_ctl_t;

    typedef enum logic [1:0] {
        MODE_CLEAR    = 2'd0,
        MODE_KEEP     = 2'd1,
        MODE_SET      = 2'd2,
        MODE_CONFLICT = 2'd3
    } cell_mode_e;

    function automatic cell_mode_e decode_mode(cell_ctl_t c);
        if (c.load && c.hold)
            return MODE_CONFLICT;
        else if (c.load)
            return MODE_SET;
        else if (c.hold)
            return MODE_KEEP;
        else
            return MODE_CLEAR;
    endfunction

    function automatic word_t latch_next(word_t cur, cell_mode_e m, logic sel,
                                         word_t src, word_t bus);
        word_t nxt;
        case (m)
            MODE_SET:      nxt = cur | src;
            MODE_KEEP:     nxt = sel ? (cur | bus) : cur;
            MODE_CONFLICT: nxt = cur;
            default:       nxt = '0;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/relay_latch_cell.sv
module relay_latch_cell
    import relay_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_ctl_t ctl,
    input  word_t     src_word,
    input  word_t     bus_in,
    output word_t     value,
    output logic      conflict
);

    word_t      state_q;
    cell_mode_e mode;

    always_comb begin
        mode = decode_mode(ctl);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= latch_next(state_q, mode, ctl.sel, src_word, bus_in);
    end

    assign value    = state_q;
    assign conflict = (mode == MODE_CONFLICT);

    // A load only ever adds bits
    assert_load_sets_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && !ctl.hold) |=> ((value & $past(src_word)) == $past(src_word)
                                     && (value & $past(value)) == $past(value)));

    // Hold without load or select keeps the value
    assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.hold && !ctl.load && !ctl.sel) |=> (value == $past(value)));

    // Releasing both controls clears the cell
    assert_release_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.hold && !ctl.load) |=> (value == '0));

    // Illegal load with hold keeps the held value
    assert_conflict_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        conflict |=> (value == $past(value)));

    // Back-feed from a busy bus while held and selected
    assert_backfeed_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.hold && !ctl.load && ctl.sel) |=> (value == ($past(value) | $past(bus_in))));

endmodule

// File: rtl/relay_bus_merge.sv
module relay_bus_merge
    import relay_bank_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic [N*DATA_W-1:0] words,
    input  logic [N-1:0]        sel,
    output word_t               bus
);

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i])
                bus = bus | words[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/relay_reg_bank.sv
module relay_reg_bank
    import relay_bank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_REGS-1:0]        load,
    input  logic [NUM_REGS-1:0]        hold,
    input  logic [NUM_REGS-1:0]        sel,
    input  logic                       src_alu_a,
    input  logic                       src_alu_d,
    input  logic [DATA_W-1:0]          bus_in,
    input  logic [DATA_W-1:0]          alu_result,
    output logic [DATA_W-1:0]          bus_out,
    output logic [DATA_W-1:0]          alu_op_b,
    output logic [DATA_W-1:0]          alu_op_c,
    output logic [NUM_REGS*DATA_W-1:0] status,
    output logic [NUM_REGS-1:0]        conflict
);

    localparam int TOTAL_W = NUM_REGS * DATA_W;

    logic [NUM_REGS-1:0] src_pick;
    logic [TOTAL_W-1:0]  packed_vals;

    always_comb begin
        src_pick        = '0;
        src_pick[IDX_A] = src_alu_a;
        src_pick[IDX_D] = src_alu_d;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        localparam bit ALU_CAPABLE = (g == int'(IDX_A)) || (g == int'(IDX_D));
        word_t     src_w;
        word_t     val_w;
        cell_ctl_t ctl_w;

        if (ALU_CAPABLE) begin : g_alu_src
            assign src_w = src_pick[g] ? alu_result : bus_in;
        end else begin : g_bus_src
            assign src_w = bus_in;
        end

        assign ctl_w = '{load: load[g], hold: hold[g], sel: sel[g]};

        relay_latch_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl_w),
            .src_word (src_w),
            .bus_in   (bus_in),
            .value    (val_w),
            .conflict (conflict[g])
        );

        assign packed_vals[g*DATA_W +: DATA_W] = val_w;
    end

    relay_bus_merge #(.N(NUM_REGS)) u_merge (
        .words (packed_vals),
        .sel   (sel),
        .bus   (bus_out)
    );

    assign status   = packed_vals;
    assign alu_op_b = packed_vals[int'(IDX_B)*DATA_W +: DATA_W];
    assign alu_op_c = packed_vals[int'(IDX_C)*DATA_W +: DATA_W];

    // Nothing selected leaves the bus empty
    assert_idle_bus_R7: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (bus_out == '0));

    // After a reset edge every register reads zero
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (status == '0));

    // B never takes the ALU result: a bus-only load with clear bus and clear state stays clear
    assert_b_bus_only_R9: assert property (@(posedge clk) disable iff (rst)
        (load[IDX_B] && !hold[IDX_B] && bus_in == '0 && alu_op_b == '0) |=> (alu_op_b == '0));

endmodule

// File: tb/relay_reg_bank_tb.sv
module relay_reg_bank_tb;
    import relay_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  load = '0, hold = '0, sel = '0;
    logic        src_alu_a = 1'b0, src_alu_d = 1'b0;
    logic [7:0]  bus_in = '0, alu_result = '0;
    logic [7:0]  bus_out, alu_op_b, alu_op_c;
    logic [31:0] status;
    logic [3:0]  conflict;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] exp_v [4];

    always #10ns clk = ~clk;

    relay_reg_bank u_dut (
        .clk(clk), .rst(rst), .load(load), .hold(hold), .sel(sel),
        .src_alu_a(src_alu_a), .src_alu_d(src_alu_d),
        .bus_in(bus_in), .alu_result(alu_result),
        .bus_out(bus_out), .alu_op_b(alu_op_b), .alu_op_c(alu_op_c),
        .status(status), .conflict(conflict)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_next(logic [7:0] cur, bit ld, bit hd, bit sl,
                                              logic [7:0] src, logic [7:0] bus);
        if (ld && hd) return cur;
        if (ld)       return cur | src;
        if (hd)       return sl ? (cur | bus) : cur;
        return 8'h00;
    endfunction

    // drive one cycle, check conflict before the edge and all outputs after it
    task automatic step(string req, logic [3:0] ld, logic [3:0] hd, logic [3:0] sl,
                        bit sa, bit sd, logic [7:0] b, logic [7:0] alu);
        logic [7:0] src;
        logic [7:0] merged;
        @(negedge clk);
        load = ld; hold = hd; sel = sl; src_alu_a = sa; src_alu_d = sd;
        bus_in = b; alu_result = alu;
        #1;
        chk("R5 conflict flag", {28'd0, conflict}, {28'd0, ld & hd});
        for (int i = 0; i < 4; i++) begin
            src = b;
            if (i == 0 && sa) src = alu;
            if (i == 3 && sd) src = alu;
            exp_v[i] = model_next(exp_v[i], ld[i], hd[i], sl[i], src, b);
        end
        @(posedge clk);
        #5;
        merged = 8'h00;
        for (int i = 0; i < 4; i++) if (sl[i]) merged = merged | exp_v[i];
        chk({req, " R10 status"}, status, {exp_v[3], exp_v[2], exp_v[1], exp_v[0]});
        chk("R7 bus_out", {24'd0, bus_out}, {24'd0, merged});
        chk("R8 alu_op_b", {24'd0, alu_op_b}, {24'd0, exp_v[1]});
        chk("R8 alu_op_c", {24'd0, alu_op_c}, {24'd0, exp_v[2]});
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) exp_v[i] = 8'h00;
        repeat (3) @(posedge clk);
        #5;
        chk("R1 reset status", status, 32'd0);
        chk("R1 reset bus", {24'd0, bus_out}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2: load twice, bits accumulate
        step("R2 first load", 4'hF, 4'h0, 4'h0, 0, 0, 8'h11, 8'h00);
        step("R2 second load ORs", 4'hF, 4'h0, 4'h0, 0, 0, 8'h82, 8'h00);
        // R3: hold keeps value while bus toggles
        step("R3 hold keeps", 4'h0, 4'hF, 4'h0, 0, 0, 8'hFF, 8'hFF);
        step("R3 hold keeps again", 4'h0, 4'hF, 4'h0, 0, 0, 8'h5A, 8'h00);
        // R5: load+hold conflict on A and C
        step("R5 conflict keeps", 4'h5, 4'hF, 4'h0, 1, 0, 8'h7C, 8'h40);
        // R6: back-feed into B while selected
        step("R6 backfeed", 4'h0, 4'hF, 4'h2, 0, 0, 8'h44, 8'h00);
        // R7: select several at once, empty bus
        step("R7 multi select", 4'h0, 4'hF, 4'hB, 0, 0, 8'h00, 8'h00);
        // R4: drop hold on B and D
        step("R4 release clears", 4'h0, 4'h5, 4'h0, 0, 0, 8'h00, 8'h00);
        step("R4 release all", 4'h0, 4'h0, 4'h0, 0, 0, 8'h00, 8'h00);
        // R9: ALU sources reach A and D only
        step("R9 alu into A and D", 4'hF, 4'h0, 4'h0, 1, 1, 8'h03, 8'hC0);
        step("R9 bus into D", 4'h8, 4'h7, 4'h0, 1, 0, 8'h24, 8'h18);
        step("R9 keep", 4'h0, 4'hF, 4'hF, 0, 0, 8'h00, 8'hFF);

        // random phase
        for (int n = 0; n < 2000; n++) begin
            logic [3:0] ld, hd;
            ld = 4'($urandom) & 4'($urandom);
            hd = 4'($urandom) | 4'($urandom);
            step("R2 R3 R4 R6 random", ld, hd, 4'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4 == 0) ? 8'($urandom) : 8'h00, 8'($urandom));
        end

        // reset mid-run
        @(negedge clk);
        rst = 1'b1;
        load = 4'hF; bus_in = 8'hFF;
        @(posedge clk);
        #5;
        chk("R1 reset mid-run", status, 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule